// File: doc/BRIEF.md
# Expansion Bus Framebuffer Slave

This block lets a 68000-style expansion bus host reach a graphics framebuffer through a 16-bit memory window. The host's asynchronous control lines (address strobe, separate upper and lower byte strobes, a direction line and a data output enable) are resynchronised to the local clock. Each host bus cycle is then decoded into at most one request on a simple request/acknowledge memory port. A write carries the bus data and a byte-enable pair taken from the strobes. A read holds the host cycle until memory answers. The returned word is latched and presented on the data bus until the host ends the cycle.

Before it has a base address, the board answers in the configuration page, but only while its chain-enable input is asserted. Reads there return identity nibbles. A write of the base byte places the board in an aligned 4 MB window and asserts the chain-enable output, which passes the chain to the next board. From then on, only addresses inside that window are answered. The configuration page goes silent.

Top module: `zbus_slave`

## Requirements
- R1: While reset is asserted and immediately after it, `bus_ack`, `bus_data_oe` and `mem_req` are 0 and `cfg_out_n` is 1.
- R2: While unconfigured and with `cfg_in_n` low, a read whose address bits A23..A16 equal 0xE8 acknowledges. For word index i = A6..A1 below 16, it returns identity nibble i (nibble 0 is the top nibble of the 64-bit identity) in D15..D12, with D11..D0 zero. Indices of 16 and above return 0.
- R3: While unconfigured and with `cfg_in_n` high, accesses to the configuration page get no acknowledge and no data drive.
- R4: An upper-strobe write to configuration word index 0x24 sets the window base to D15..D14 (host A23..A22) and marks the board configured. `cfg_out_n` then goes low and stays low.
- R5: Only a configured board whose address A23..A22 equals the base issues memory requests. Every other access, including one to the configuration page after configuration, gets no request, no acknowledge and no drive.
- R6: A window write makes one request with `mem_we`=1, `mem_addr` = A21..A1, `mem_wdata` = bus data, and `mem_be` = {upper strobe active, lower strobe active}. Only the enabled bytes are stored.
- R7: A window read makes one request with `mem_we`=0. `bus_ack` rises only after `mem_ack`. `bus_data_out` holds the word that came with `mem_ack`, unchanged until the address strobe is released.
- R8: `bus_data_oe` is 1 only while an acknowledged read hit is in progress and `bus_doe` is high. A read with `bus_doe` low is acknowledged without a drive.
- R9: `mem_req` stays asserted, with stable address, until `mem_ack`. Each access issues exactly one request.
- R10: Within 6 cycles of the address strobe being released, `bus_ack` and `bus_data_oe` return to 0.
- R11: A write is not decoded until a data strobe is active. An address strobe with no data strobe produces no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_as_n | input | 1 | Address strobe, active low |
| bus_uds_n | input | 1 | Upper byte strobe (D15..D8), active low |
| bus_lds_n | input | 1 | Lower byte strobe (D7..D0), active low |
| bus_read | input | 1 | 1 = read, 0 = write |
| bus_doe | input | 1 | Host expects the slave to drive data |
| bus_addr | input | 23 | Word address, bit k is A(k+1) |
| bus_data_in | input | 16 | Data from host |
| bus_data_out | output | 16 | Data to host |
| bus_data_oe | output | 1 | Enable for the data bus drivers |
| bus_ack | output | 1 | Cycle complete, data valid for reads |
| cfg_in_n | input | 1 | Configuration chain enable in, active low |
| cfg_out_n | output | 1 | Configuration chain enable out, active low |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write request |
| mem_addr | output | 21 | Word address inside the window |
| mem_be | output | 2 | Byte enables, bit 1 = high byte |
| mem_wdata | output | 16 | Write data |
| mem_ack | input | 1 | One-cycle memory acknowledge |
| mem_rdata | input | 16 | Read data, valid with `mem_ack` |

## Verification
The bench holds back the byte strobes of writes for several cycles after the address strobe. A design that decoded at the address strobe alone would issue a request with empty byte enables and stale data. The memory model replaces its read data with noise after every acknowledge, so a design that forwarded `mem_rdata` instead of latching it returns garbage while the bus cycle is held. Single-byte writes and word writes are compared against a reference array, which exposes swapped or ignored strobes. The identity page is checked with the chain enable high, with it low, and after configuration. Off-window accesses and reads with the output enable low catch a slave that answers or drives when it must stay silent.

// File: rtl/zbs_pkg.sv
package zbs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_STROBE,
    ST_MEM,
    ST_DONE,
    ST_IGNORE
  } zbs_state_e;
endpackage

// File: rtl/zbs_sync.sv
module zbs_sync #(
  parameter int             W       = 1,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d;
      s2_q <= s1_q;
    end
  end

  assign q = s2_q;
endmodule

// File: rtl/zbs_decode.sv
module zbs_decode #(
  parameter int          DATA_W   = 16,
  parameter int          WIN_BITS = 2,
  parameter int          PAGE_W   = 8,
  parameter int          IDX_W    = 6,
  parameter logic [7:0]  CFG_PAGE = 8'hE8,
  parameter logic [5:0]  BASE_IDX = 6'h24,
  parameter logic [63:0] IDENT    = 64'hC2F0_5A3E_9017_B6D4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [PAGE_W-1:0]   page,
  input  logic [WIN_BITS-1:0] win,
  input  logic [IDX_W-1:0]    idx,
  input  logic                cfg_in_n_s,
  input  logic                cfg_wr,
  input  logic [WIN_BITS-1:0] cfg_wdata,
  output logic                cfg_hit,
  output logic                win_hit,
  output logic                base_sel,
  output logic [DATA_W-1:0]   cfg_rdata,
  output logic                configured
);
  localparam int NIB = 16;

  logic                configured_q, configured_d;
  logic [WIN_BITS-1:0] base_q, base_d;

  always_comb begin
    configured_d = configured_q | cfg_wr;
    base_d       = cfg_wr ? cfg_wdata : base_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      configured_q <= 1'b0;
      base_q       <= '0;
    end else if (cfg_wr) begin
      configured_q <= configured_d;
      base_q       <= base_d;
    end
  end

  assign configured = configured_q;
  assign cfg_hit    = !configured_q && !cfg_in_n_s && (page == PAGE_W'(CFG_PAGE));
  assign win_hit    = configured_q && (win == base_q);
  assign base_sel   = (idx == IDX_W'(BASE_IDX));

  always_comb begin
    cfg_rdata = '0;
    for (int i = 0; i < NIB; i++) begin
      if (idx == IDX_W'(i)) cfg_rdata[DATA_W-1 -: 4] = IDENT[63-4*i -: 4];
    end
  end
endmodule

// File: rtl/zbs_ctrl.sv
module zbs_ctrl #(
  parameter int ADDR_W = 23,
  parameter int DATA_W = 16,
  parameter int MEM_AW = 21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              as_n_s,
  input  logic              uds_n_s,
  input  logic              lds_n_s,
  input  logic              read_s,
  input  logic              doe_s,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_data_in,
  input  logic              cfg_hit,
  input  logic              win_hit,
  input  logic              base_sel,
  input  logic [DATA_W-1:0] cfg_rdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] addr_q,
  output logic              cfg_wr,
  output logic              mem_req,
  output logic              mem_we,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [1:0]        mem_be,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              bus_ack,
  output logic              bus_data_oe,
  output logic [DATA_W-1:0] bus_data_out
);
  import zbs_pkg::*;

  zbs_state_e        st_q, st_d;
  logic              as_prev_q;
  logic [ADDR_W-1:0] addr_d;
  logic              read_q, read_d;
  logic [1:0]        be_q, be_d;
  logic [DATA_W-1:0] wdata_q, wdata_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              as_fall, strobe_any;

  assign as_fall    = as_prev_q && !as_n_s;
  assign strobe_any = !uds_n_s || !lds_n_s;

  always_comb begin
    st_d    = st_q;
    addr_d  = addr_q;
    read_d  = read_q;
    be_d    = be_q;
    wdata_d = wdata_q;
    rdata_d = rdata_q;
    cfg_wr  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (as_fall) begin
          addr_d = bus_addr;
          st_d   = ST_STROBE;
        end
      end
      ST_STROBE: begin
        if (as_n_s) begin
          st_d = ST_IDLE;
        end else if (strobe_any) begin
          read_d  = read_s;
          be_d    = {!uds_n_s, !lds_n_s};
          wdata_d = bus_data_in;
          if (cfg_hit) begin
            if (read_s) rdata_d = cfg_rdata;
            else        cfg_wr  = base_sel && !uds_n_s;
            st_d = ST_DONE;
          end else if (win_hit) begin
            st_d = ST_MEM;
          end else begin
            st_d = ST_IGNORE;
          end
        end
      end
      ST_MEM: begin
        if (mem_ack) begin
          if (read_q) rdata_d = mem_rdata;
          st_d = ST_DONE;
        end
      end
      ST_DONE, ST_IGNORE: begin
        if (as_n_s) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      as_prev_q <= 1'b1;
      addr_q    <= '0;
      read_q    <= 1'b1;
      be_q      <= '0;
      wdata_q   <= '0;
      rdata_q   <= '0;
    end else begin
      st_q      <= st_d;
      as_prev_q <= as_n_s;
      addr_q    <= addr_d;
      read_q    <= read_d;
      be_q      <= be_d;
      wdata_q   <= wdata_d;
      rdata_q   <= rdata_d;
    end
  end

  assign mem_req      = (st_q == ST_MEM);
  assign mem_we       = !read_q;
  assign mem_addr     = addr_q[MEM_AW-1:0];
  assign mem_be       = be_q;
  assign mem_wdata    = wdata_q;
  assign bus_ack      = (st_q == ST_DONE);
  assign bus_data_oe  = (st_q == ST_DONE) && read_q && doe_s;
  assign bus_data_out = rdata_q;
endmodule

// File: rtl/zbus_slave.sv
module zbus_slave #(
  parameter int          ADDR_W   = 23,
  parameter int          DATA_W   = 16,
  parameter int          WIN_BITS = 2,
  parameter logic [63:0] IDENT    = 64'hC2F0_5A3E_9017_B6D4,
  parameter int          MEM_AW   = ADDR_W - WIN_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_as_n,
  input  logic              bus_uds_n,
  input  logic              bus_lds_n,
  input  logic              bus_read,
  input  logic              bus_doe,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_data_in,
  output logic [DATA_W-1:0] bus_data_out,
  output logic              bus_data_oe,
  output logic              bus_ack,
  input  logic              cfg_in_n,
  output logic              cfg_out_n,
  output logic              mem_req,
  output logic              mem_we,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [1:0]        mem_be,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata
);
  localparam int PAGE_W = 8;
  localparam int IDX_W  = 6;

  logic              rst_s1_q, rst_s2_q, rst_int_n;
  logic [5:0]        raw, syn;
  logic [ADDR_W-1:0] addr_q;
  logic              cfg_hit, win_hit, base_sel, cfg_wr, configured;
  logic [DATA_W-1:0] cfg_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end
  assign rst_int_n = rst_s2_q;

  assign raw = {bus_as_n, bus_uds_n, bus_lds_n, bus_read, bus_doe, cfg_in_n};

  zbs_sync #(.W(6), .RST_VAL(6'b111101)) u_sync (
    .clk(clk), .rst_n(rst_int_n), .d(raw), .q(syn)
  );

  zbs_decode #(
    .DATA_W(DATA_W), .WIN_BITS(WIN_BITS), .PAGE_W(PAGE_W), .IDX_W(IDX_W), .IDENT(IDENT)
  ) u_dec (
    .clk(clk), .rst_n(rst_int_n),
    .page(addr_q[ADDR_W-1 -: PAGE_W]),
    .win(addr_q[ADDR_W-1 -: WIN_BITS]),
    .idx(addr_q[IDX_W-1:0]),
    .cfg_in_n_s(syn[0]),
    .cfg_wr(cfg_wr),
    .cfg_wdata(bus_data_in[DATA_W-1 -: WIN_BITS]),
    .cfg_hit(cfg_hit), .win_hit(win_hit), .base_sel(base_sel),
    .cfg_rdata(cfg_rdata), .configured(configured)
  );

  zbs_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MEM_AW(MEM_AW)) u_ctrl (
    .clk(clk), .rst_n(rst_int_n),
    .as_n_s(syn[5]), .uds_n_s(syn[4]), .lds_n_s(syn[3]), .read_s(syn[2]), .doe_s(syn[1]),
    .bus_addr(bus_addr), .bus_data_in(bus_data_in),
    .cfg_hit(cfg_hit), .win_hit(win_hit), .base_sel(base_sel), .cfg_rdata(cfg_rdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .addr_q(addr_q), .cfg_wr(cfg_wr),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .bus_ack(bus_ack), .bus_data_oe(bus_data_oe),
    .bus_data_out(bus_data_out)
  );

  assign cfg_out_n = !configured;
endmodule

// File: rtl/zbs_chk.sv
module zbs_chk #(
  parameter int DATA_W = 16,
  parameter int MEM_AW = 21
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_req,
  input logic              mem_ack,
  input logic [MEM_AW-1:0] mem_addr,
  input logic              bus_ack,
  input logic              bus_data_oe,
  input logic [DATA_W-1:0] bus_data_out,
  input logic              cfg_out_n
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req); // R9
  AST_REQ_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> $stable(mem_addr)); // R9
  AST_ACK_AFTER_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !bus_ack); // R7
  AST_RDATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_data_oe && $past(bus_data_oe) |-> $stable(bus_data_out)); // R7
  AST_OE_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    bus_data_oe |-> bus_ack); // R8
  AST_CHAIN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_out_n |=> !cfg_out_n); // R4
endmodule

bind zbus_slave zbs_chk #(.DATA_W(DATA_W), .MEM_AW(MEM_AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_ack(mem_ack), .mem_addr(mem_addr),
  .bus_ack(bus_ack), .bus_data_oe(bus_data_oe), .bus_data_out(bus_data_out),
  .cfg_out_n(cfg_out_n)
);

// File: tb/zbus_slave_tb.sv
module zbus_slave_tb;
  localparam logic [63:0] ID = 64'hC2F0_5A3E_9017_B6D4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_as_n, bus_uds_n, bus_lds_n, bus_read, bus_doe, cfg_in_n;
  logic [22:0] bus_addr;
  logic [15:0] bus_data_in, bus_data_out, mem_wdata, mem_rdata;
  logic        bus_data_oe, bus_ack, cfg_out_n, mem_req, mem_we, mem_ack;
  logic [20:0] mem_addr;
  logic [1:0]  mem_be;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [15:0] fb_mem  [256];
  logic [15:0] ref_mem [256];
  int          req_cnt = 0;
  logic [20:0] lr_addr;
  logic        lr_we;
  logic [1:0]  lr_be;
  logic [15:0] lr_wdata;

  always #5 clk = ~clk;

  zbus_slave u_dut (
    .clk(clk), .rst_n(rst_n), .bus_as_n(bus_as_n), .bus_uds_n(bus_uds_n),
    .bus_lds_n(bus_lds_n), .bus_read(bus_read), .bus_doe(bus_doe), .bus_addr(bus_addr),
    .bus_data_in(bus_data_in), .bus_data_out(bus_data_out), .bus_data_oe(bus_data_oe),
    .bus_ack(bus_ack), .cfg_in_n(cfg_in_n), .cfg_out_n(cfg_out_n), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] merge(input logic [15:0] o, input logic [15:0] d, input logic [1:0] s);
    return {s[1] ? d[15:8] : o[15:8], s[0] ? d[7:0] : o[7:0]};
  endfunction

  function automatic logic [15:0] ident_exp(input int i);
    if (i < 16) return {ID[63-4*i -: 4], 12'h000};
    return 16'h0000;
  endfunction

  // framebuffer model
  initial begin
    mem_ack = 1'b0;
    mem_rdata = 16'h0;
    for (int i = 0; i < 256; i++) begin
      fb_mem[i]  = 16'(i * 16'h0101 ^ 16'h5A3C);
      ref_mem[i] = 16'(i * 16'h0101 ^ 16'h5A3C);
    end
    forever begin
      @(negedge clk);
      if (mem_req && !mem_ack) begin
        repeat ($urandom % 4) @(negedge clk);
        lr_addr = mem_addr; lr_we = mem_we; lr_be = mem_be; lr_wdata = mem_wdata;
        if (mem_we) fb_mem[mem_addr[7:0]] = merge(fb_mem[mem_addr[7:0]], mem_wdata, mem_be);
        else        mem_rdata = fb_mem[mem_addr[7:0]];
        mem_ack = 1'b1;
        req_cnt++;
        @(negedge clk);
        mem_ack = 1'b0;
        mem_rdata = 16'($urandom);
      end
    end
  end

  task automatic host_cycle(input logic [22:0] a, input logic rd, input logic [1:0] strb,
                            input logic [15:0] wd, input logic doe,
                            output logic got_ack, output logic [15:0] rdat, output logic roe,
                            output logic early_req, output logic stable_ok, output logic released);
    @(negedge clk);
    bus_addr = a; bus_read = rd; bus_data_in = wd; bus_doe = rd & doe; bus_as_n = 1'b0;
    early_req = 1'b0;
    if (!rd) begin
      for (int i = 0; i < 6; i++) begin
        @(negedge clk);
        if (mem_req) early_req = 1'b1;
      end
    end
    bus_uds_n = ~strb[1]; bus_lds_n = ~strb[0];
    got_ack = 1'b0; rdat = 16'h0; roe = 1'b0; stable_ok = 1'b1;
    for (int i = 0; i < 40 && !got_ack; i++) begin
      @(negedge clk);
      if (bus_ack) got_ack = 1'b1;
    end
    if (got_ack) begin
      rdat = bus_data_out; roe = bus_data_oe;
      repeat (3) @(negedge clk);
      stable_ok = (bus_data_out == rdat) && (bus_data_oe == roe) && bus_ack;
    end else begin
      roe = bus_data_oe;
    end
    bus_as_n = 1'b1; bus_uds_n = 1'b1; bus_lds_n = 1'b1; bus_doe = 1'b0;
    released = 1'b0;
    for (int i = 0; i < 6 && !released; i++) begin
      @(negedge clk);
      if (!bus_ack && !bus_data_oe) released = 1'b1;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic ga, oe, er, st, rel;
    logic [15:0] rdat;
    logic [22:0] a;
    logic [1:0] s;
    logic [15:0] d;
    int c0, idx;
    void'($urandom(32'h00C0FFEE));
    rst_n = 1'b0;
    bus_as_n = 1'b1; bus_uds_n = 1'b1; bus_lds_n = 1'b1; bus_read = 1'b1; bus_doe = 1'b0;
    cfg_in_n = 1'b1; bus_addr = '0; bus_data_in = '0;
    repeat (4) @(negedge clk);
    chk(!bus_ack && !bus_data_oe && !mem_req && cfg_out_n, "R1 in reset",
        {bus_ack, bus_data_oe, mem_req, cfg_out_n}, 4'b0001);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!bus_ack && !bus_data_oe && !mem_req && cfg_out_n, "R1 after reset",
        {bus_ack, bus_data_oe, mem_req, cfg_out_n}, 4'b0001);

    // R3: chain enable not asserted
    host_cycle({8'hE8, 9'h0, 6'h00}, 1'b1, 2'b11, 16'h0, 1'b1, ga, rdat, oe, er, st, rel);
    chk(!ga && !oe, "R3 cfg page silent", {ga, oe}, 2'b00);

    // R5: window access before configuration
    c0 = req_cnt;
    host_cycle({2'b01, 13'h0, 8'h10}, 1'b0, 2'b11, 16'h1234, 1'b0, ga, rdat, oe, er, st, rel);
    chk(!ga && (req_cnt == c0), "R5 unconfigured window", {ga, 8'(req_cnt - c0)}, 0);

    // R2: identity read-out
    cfg_in_n = 1'b0;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 18; i++) begin
      host_cycle({8'hE8, 9'h0, 6'(i)}, 1'b1, 2'b11, 16'h0, 1'b1, ga, rdat, oe, er, st, rel);
      chk(ga && oe && rdat == ident_exp(i), "R2 identity nibble", rdat, ident_exp(i));
    end
    chk(cfg_out_n, "R4 chain held before config", cfg_out_n, 1);

    // R4: base write, window 01
    host_cycle({8'hE8, 9'h0, 6'h24}, 1'b0, 2'b10, 16'h4000, 1'b0, ga, rdat, oe, er, st, rel);
    chk(ga, "R4 base write acked", ga, 1);
    repeat (2) @(negedge clk);
    chk(!cfg_out_n, "R4 chain out asserted", cfg_out_n, 0);

    // R5: configuration page now silent
    host_cycle({8'hE8, 9'h0, 6'h00}, 1'b1, 2'b11, 16'h0, 1'b1, ga, rdat, oe, er, st, rel);
    chk(!ga && !oe, "R5 cfg page after config", {ga, oe}, 2'b00);

    // directed: single high byte, single low byte, then read back
    for (int k = 0; k < 2; k++) begin
      s = (k == 0) ? 2'b10 : 2'b01;
      c0 = req_cnt;
      host_cycle({2'b01, 13'h0, 8'h20}, 1'b0, s, 16'hA55A, 1'b0, ga, rdat, oe, er, st, rel);
      ref_mem[8'h20] = merge(ref_mem[8'h20], 16'hA55A, s);
      chk(ga && lr_be == s && lr_we, "R6 byte write enables", {lr_we, lr_be}, {1'b1, s});
      chk(!er, "R11 no request before strobe", er, 0);
      chk(req_cnt - c0 == 1, "R9 one request", req_cnt - c0, 1);
    end
    host_cycle({2'b01, 13'h0, 8'h20}, 1'b1, 2'b11, 16'h0, 1'b1, ga, rdat, oe, er, st, rel);
    chk(rdat == ref_mem[8'h20], "R6 byte merge readback", rdat, ref_mem[8'h20]);

    // R8: read with output enable low
    host_cycle({2'b01, 13'h0, 8'h21}, 1'b1, 2'b11, 16'h0, 1'b0, ga, rdat, oe, er, st, rel);
    chk(ga && !oe, "R8 no drive without doe", {ga, oe}, 2'b10);

    // random traffic
    for (int n = 0; n < 160; n++) begin
      idx = int'($urandom % 256);
      a = {2'b01, 13'($urandom), 8'(idx)};
      d = 16'($urandom);
      c0 = req_cnt;
      if ($urandom % 2) begin
        case ($urandom % 3)
          0: s = 2'b10;
          1: s = 2'b01;
          default: s = 2'b11;
        endcase
        host_cycle(a, 1'b0, s, d, 1'b0, ga, rdat, oe, er, st, rel);
        ref_mem[idx] = merge(ref_mem[idx], d, s);
        chk(ga && lr_we && lr_addr == a[20:0] && lr_be == s && lr_wdata == d,
            "R6 write request", {lr_addr, lr_be, lr_we}, {a[20:0], s, 1'b1});
        chk(!er, "R11 write waits for strobe", er, 0);
      end else begin
        host_cycle(a, 1'b1, 2'b11, 16'h0, 1'b1, ga, rdat, oe, er, st, rel);
        chk(ga && oe && !lr_we && lr_addr == a[20:0] && rdat == ref_mem[idx],
            "R7 read data", rdat, ref_mem[idx]);
        chk(st, "R7 read data held", st, 1);
      end
      chk(req_cnt - c0 == 1, "R9 one request per access", req_cnt - c0, 1);
      chk(rel, "R10 release after strobe", rel, 1);
    end

    // R5: off-window accesses
    for (int n = 0; n < 12; n++) begin
      logic [1:0] w;
      w = 2'($urandom);
      if (w == 2'b01) w = 2'b10;
      c0 = req_cnt;
      host_cycle({w, 21'($urandom)}, n[0], 2'b11, 16'hFFFF, 1'b1, ga, rdat, oe, er, st, rel);
      chk(!ga && !oe && req_cnt == c0, "R5 off-window ignored", {ga, oe, 8'(req_cnt - c0)}, 0);
    end
    chk(!cfg_out_n, "R4 chain out stays", cfg_out_n, 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule